// File: doc/BRIEF.md
# Host Byte Port Steering

This block sits between an external host that owns an 8-bit parallel bus and a processor that sees two 16-bit words. The host writes bytes into an inbound word, which the processor collects. The processor loads an outbound word, which the host reads out byte by byte. Two host select lines pick the byte on the bus. A status-select line chooses between data and a status byte. A byte-select line chooses which byte of the word is used.

A static configuration byte sets the port's behaviour. It chooses byte-wide or word-wide transfers and can swap the sense of the byte-select line. It also sets the polarity of the two flag pins, can merge both flags onto the full pin, and can invert the empty bit in the status byte only. The block keeps an inbound-full flag and an outbound-empty flag. Host and processor transfers set and clear them, and the block shows them on the pins and in the status byte.

Top module: `host_byte_port`

## Requirements
- R1: After reset the inbound-full flag is 0, the outbound-empty flag is 1, and both data words are zero.
- R2: The effective select is host_sel_byte XOR cfg[2]. With host_sel_stat=0 and effective select 0, the host reaches the low data byte. In word mode (cfg[0]=1), effective select 1 reaches the high byte. With host_sel_stat=1 and effective select 0, the host reaches the status byte.
- R3: Reserved selections read as 0x00. Writes to them change neither word, and accesses to them change no flag. Reserved selections are effective select 1 in byte mode (cfg[0]=0) and effective select 1 with host_sel_stat=1.
- R4: The status byte holds inbound-full in bit 1 and outbound-empty in bit 0, and bits 7..2 read 0. When cfg[7]=1, bit 0 is inverted. The status byte is read-only.
- R5: In byte mode, a host write to the low byte sets inbound-full in the following cycle. A host read of the low byte sets outbound-empty.
- R6: In word mode, only a data access made with host_sel_byte=1 completes the word and sets the flag for its direction. The other byte leaves the flags unchanged.
- R7: A processor read pulse clears inbound-full. A processor write pulse loads the outbound word and clears outbound-empty. If a host write completes in the same cycle as a processor read, inbound-full ends up set. If a processor write and a host read complete in the same cycle, outbound-empty ends up clear.
- R8: With cfg[1]=0, both flag pins are active high. With cfg[1]=1, both pins are inverted. cfg[7] never changes the empty pin.
- R9: With cfg[5]=1, the full pin carries (inbound-full OR outbound-empty) before the polarity from cfg[1] is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg | input | 8 | Configuration: 0 word mode, 1 pin invert, 2 byte swap, 5 merge flags, 7 status empty invert |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_sel_stat | input | 1 | 1 selects status, 0 selects data |
| host_sel_byte | input | 1 | Byte select line |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte presented to the host for the current selection |
| ibf_pin | output | 1 | Inbound-full pin |
| obe_pin | output | 1 | Outbound-empty pin |
| cpu_wr_out | input | 1 | Processor loads the outbound word |
| cpu_out_word | input | 16 | Outbound word from the processor |
| cpu_rd_in | input | 1 | Processor takes the inbound word |
| cpu_in_word | output | 16 | Inbound word assembled from host bytes |

## Verification
The bench checks word mode with and without the swap bit. A design that tied word completion to the high byte, rather than to the byte-select line, would raise its flags one byte early once the bytes are swapped. It also reads and writes every reserved selection. A design that decoded too loosely would return data there, overwrite a word byte, or move a flag. Same-cycle collisions between host and processor events are driven on purpose, so a reversed priority leaves a stale flag. The bench also sets the status-invert bit together with the pin controls, to catch an inversion that reaches the empty pin.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    typedef enum logic [1:0] {
        ACC_LO   = 2'd0,
        ACC_HI   = 2'd1,
        ACC_STAT = 2'd2,
        ACC_RSV  = 2'd3
    } acc_e;

    localparam int CFG_WORD     = 0;
    localparam int CFG_PIN_INV  = 1;
    localparam int CFG_SWAP     = 2;
    localparam int CFG_MERGE    = 5;
    localparam int CFG_STAT_INV = 7;

    localparam int STAT_FULL_BIT  = 1;
    localparam int STAT_EMPTY_BIT = 0;

    typedef struct packed {
        logic full;
        logic empty;
    } flag_s;
endpackage

// File: rtl/hbs_decode.sv
module hbs_decode
    import hbs_pkg::*;
(
    input  logic word_mode,
    input  logic swap,
    input  logic sel_stat,
    input  logic sel_byte,
    output acc_e acc,
    output logic completes
);
    logic eff_sel;

    always_comb begin
        eff_sel = sel_byte ^ swap;
        if (sel_stat) begin
            acc = eff_sel ? ACC_RSV : ACC_STAT;
        end else if (!eff_sel) begin
            acc = ACC_LO;
        end else begin
            acc = word_mode ? ACC_HI : ACC_RSV;
        end
        // the last byte in host order finishes a word; in byte mode the low byte is the only one
        if (acc == ACC_LO || acc == ACC_HI) begin
            completes = word_mode ? sel_byte : 1'b1;
        end else begin
            completes = 1'b0;
        end
    end
endmodule

// File: rtl/hbs_regs.sv
module hbs_regs
    import hbs_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  acc_e              acc,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cpu_wr,
    input  logic [WORD_W-1:0] cpu_word,
    output logic [WORD_W-1:0] in_word,
    output logic [WORD_W-1:0] out_word
);
    typedef struct packed {
        logic [WORD_W-1:0] inw;
        logic [WORD_W-1:0] outw;
    } regs_s;

    regs_s r_d, r_q;
    logic [1:0] lane_we;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        if (g == 0) begin : g_lo
            assign lane_we[g] = host_wr && (acc == ACC_LO);
        end else begin : g_hi
            assign lane_we[g] = host_wr && (acc == ACC_HI);
        end
    end

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < 2; i++) begin
            if (lane_we[i]) r_d.inw[i*BYTE_W +: BYTE_W] = wdata;
        end
        if (cpu_wr) r_d.outw = cpu_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign in_word  = r_q.inw;
    assign out_word = r_q.outw;

    // reserved and status selections never reach the inbound word
    p_rsv_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (acc == ACC_RSV || acc == ACC_STAT)) |=> $stable(in_word));
    p_cpu_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> (out_word == $past(cpu_word)));
endmodule

// File: rtl/hbs_flags.sv
module hbs_flags
    import hbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_done,
    input  logic  rd_done,
    input  logic  cpu_rd,
    input  logic  cpu_wr,
    output flag_s flags
);
    flag_s f_d, f_q;

    always_comb begin
        f_d = f_q;
        // new host data wins over a processor read
        if (wr_done)     f_d.full = 1'b1;
        else if (cpu_rd) f_d.full = 1'b0;
        // new processor data wins over a host read
        if (cpu_wr)       f_d.empty = 1'b0;
        else if (rd_done) f_d.empty = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{full: 1'b0, empty: 1'b1};
        else        f_q <= f_d;
    end

    assign flags = f_q;

    p_full_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> flags.full);
    p_full_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !wr_done) |=> !flags.full);
    p_empty_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> !flags.empty);
    p_empty_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !cpu_wr) |=> flags.empty);
    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_done && !cpu_rd) |=> $stable(flags.full));
endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
    import hbs_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic              host_sel_stat,
    input  logic              host_sel_byte,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              ibf_pin,
    output logic              obe_pin,
    input  logic              cpu_wr_out,
    input  logic [WORD_W-1:0] cpu_out_word,
    input  logic              cpu_rd_in,
    output logic [WORD_W-1:0] cpu_in_word
);
    acc_e              acc;
    logic              completes;
    flag_s             flags;
    logic [WORD_W-1:0] out_word;
    logic [BYTE_W-1:0] stat_byte;
    logic              full_src;
    logic              unused_cfg;

    assign unused_cfg = ^{cfg[6], cfg[4:3]};

    hbs_decode u_decode (
        .word_mode (cfg[CFG_WORD]),
        .swap      (cfg[CFG_SWAP]),
        .sel_stat  (host_sel_stat),
        .sel_byte  (host_sel_byte),
        .acc       (acc),
        .completes (completes)
    );

    hbs_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_wr  (host_wr),
        .acc      (acc),
        .wdata    (host_wdata),
        .cpu_wr   (cpu_wr_out),
        .cpu_word (cpu_out_word),
        .in_word  (cpu_in_word),
        .out_word (out_word)
    );

    hbs_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_done (host_wr && completes),
        .rd_done (host_rd && completes),
        .cpu_rd  (cpu_rd_in),
        .cpu_wr  (cpu_wr_out),
        .flags   (flags)
    );

    always_comb begin
        stat_byte                 = '0;
        stat_byte[STAT_FULL_BIT]  = flags.full;
        stat_byte[STAT_EMPTY_BIT] = flags.empty ^ cfg[CFG_STAT_INV];
        unique case (acc)
            ACC_LO:   host_rdata = out_word[BYTE_W-1:0];
            ACC_HI:   host_rdata = out_word[WORD_W-1:BYTE_W];
            ACC_STAT: host_rdata = stat_byte;
            default:  host_rdata = '0;
        endcase
        full_src = cfg[CFG_MERGE] ? (flags.full | flags.empty) : flags.full;
        ibf_pin  = full_src ^ cfg[CFG_PIN_INV];
        obe_pin  = flags.empty ^ cfg[CFG_PIN_INV];
    end

    p_rsv_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_RSV) |-> (host_rdata == '0));
    p_stat_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_STAT) |-> (host_rdata[BYTE_W-1:2] == '0 && host_rdata[1] == flags.full));
    p_obe_pin_ignores_stat_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[CFG_PIN_INV]) |-> (obe_pin == flags.empty));
    p_rsv_no_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_rd || host_wr) && acc == ACC_RSV && !cpu_rd_in && !cpu_wr_out) |=> $stable(flags));
endmodule

// File: tb/host_byte_port_bench.sv
`timescale 1ns/1ps
module host_byte_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg = 8'h00;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_sel_stat = 1'b0;
    logic        host_sel_byte = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        ibf_pin;
    logic        obe_pin;
    logic        cpu_wr_out = 1'b0;
    logic [15:0] cpu_out_word = 16'h0000;
    logic        cpu_rd_in = 1'b0;
    logic [15:0] cpu_in_word;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    host_byte_port u_host_byte_port (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .host_rd(host_rd), .host_wr(host_wr),
        .host_sel_stat(host_sel_stat), .host_sel_byte(host_sel_byte),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ibf_pin(ibf_pin), .obe_pin(obe_pin),
        .cpu_wr_out(cpu_wr_out), .cpu_out_word(cpu_out_word),
        .cpu_rd_in(cpu_rd_in), .cpu_in_word(cpu_in_word)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic st, input logic bs, input logic [7:0] d);
        @(negedge clk);
        host_sel_stat = st; host_sel_byte = bs; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        #1;
    endtask

    task automatic hread(input logic st, input logic bs, output logic [7:0] d);
        @(negedge clk);
        host_sel_stat = st; host_sel_byte = bs; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
        #1;
    endtask

    // look at a selection without a strobe
    task automatic peek(input logic st, input logic bs, output logic [7:0] d);
        @(negedge clk);
        host_sel_stat = st; host_sel_byte = bs;
        #1 d = host_rdata;
    endtask

    task automatic cwrite(input logic [15:0] w);
        @(negedge clk);
        cpu_out_word = w; cpu_wr_out = 1'b1;
        @(negedge clk);
        cpu_wr_out = 1'b0;
        #1;
    endtask

    task automatic cread();
        @(negedge clk);
        cpu_rd_in = 1'b1;
        @(negedge clk);
        cpu_rd_in = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 full pin after reset", {15'd0, ibf_pin}, 16'd0);
        check("R1 empty pin after reset", {15'd0, obe_pin}, 16'd1);
        check("R1 inbound word after reset", cpu_in_word, 16'h0000);
        peek(1'b0, 1'b0, d);
        check("R1 outbound low after reset", {8'd0, d}, 16'h0000);
        peek(1'b1, 1'b0, d);
        check("R4 status after reset", {8'd0, d}, 16'h0001);
    endtask

    task automatic t_byte_mode();
        logic [7:0] d;
        cfg = 8'h00;
        cwrite(16'hA55A);
        check("R7 write clears empty", {15'd0, obe_pin}, 16'd0);
        hread(1'b0, 1'b0, d);
        check("R2 byte mode low byte", {8'd0, d}, 16'h005A);
        check("R5 low read sets empty", {15'd0, obe_pin}, 16'd1);
        hwrite(1'b0, 1'b0, 8'h3C);
        check("R5 low write data", cpu_in_word, 16'h003C);
        check("R5 low write sets full", {15'd0, ibf_pin}, 16'd1);
        cread();
        check("R7 read clears full", {15'd0, ibf_pin}, 16'd0);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        cfg = 8'h00;
        cwrite(16'h1234);
        hread(1'b0, 1'b1, d);
        check("R3 byte mode high reads zero", {8'd0, d}, 16'h0000);
        check("R3 reserved read keeps empty", {15'd0, obe_pin}, 16'd0);
        hread(1'b1, 1'b1, d);
        check("R3 status reserved reads zero", {8'd0, d}, 16'h0000);
        hwrite(1'b0, 1'b1, 8'hFF);
        check("R3 reserved write ignored", cpu_in_word, 16'h003C);
        check("R3 reserved write keeps full", {15'd0, ibf_pin}, 16'd0);
        hwrite(1'b1, 1'b0, 8'hFF);
        check("R4 status write ignored", cpu_in_word, 16'h003C);
        check("R4 status write keeps full", {15'd0, ibf_pin}, 16'd0);
        hread(1'b0, 1'b0, d);
        check("R2 low byte after reserved", {8'd0, d}, 16'h0034);
    endtask

    task automatic t_word_mode();
        logic [7:0] d;
        cfg = 8'h01;
        cwrite(16'hBEEF);
        hread(1'b0, 1'b0, d);
        check("R2 word mode low", {8'd0, d}, 16'h00EF);
        check("R6 first byte keeps empty clear", {15'd0, obe_pin}, 16'd0);
        hread(1'b0, 1'b1, d);
        check("R2 word mode high", {8'd0, d}, 16'h00BE);
        check("R6 second byte sets empty", {15'd0, obe_pin}, 16'd1);
        hwrite(1'b0, 1'b0, 8'h11);
        check("R6 first write keeps full clear", {15'd0, ibf_pin}, 16'd0);
        hwrite(1'b0, 1'b1, 8'h22);
        check("R6 word assembled", cpu_in_word, 16'h2211);
        check("R6 second write sets full", {15'd0, ibf_pin}, 16'd1);
        cread();
    endtask

    task automatic t_swap();
        logic [7:0] d;
        cfg = 8'h05;
        cwrite(16'hCAFE);
        hread(1'b0, 1'b0, d);
        check("R2 swapped select 0 is high", {8'd0, d}, 16'h00CA);
        check("R6 swapped first byte keeps empty", {15'd0, obe_pin}, 16'd0);
        hread(1'b0, 1'b1, d);
        check("R2 swapped select 1 is low", {8'd0, d}, 16'h00FE);
        check("R6 swapped completion sets empty", {15'd0, obe_pin}, 16'd1);
        hwrite(1'b0, 1'b0, 8'h77);
        check("R6 swapped first write keeps full", {15'd0, ibf_pin}, 16'd0);
        hwrite(1'b0, 1'b1, 8'h88);
        check("R6 swapped word", cpu_in_word, 16'h7788);
        check("R6 swapped completion sets full", {15'd0, ibf_pin}, 16'd1);
        cread();
        peek(1'b1, 1'b1, d);
        check("R2 swapped status select", {8'd0, d}, 16'h0001);
        peek(1'b1, 1'b0, d);
        check("R3 swapped status reserved", {8'd0, d}, 16'h0000);
        cfg = 8'h04;
        peek(1'b0, 1'b1, d);
        check("R2 byte mode swapped low", {8'd0, d}, 16'h00FE);
        peek(1'b0, 1'b0, d);
        check("R3 byte mode swapped reserved", {8'd0, d}, 16'h0000);
    endtask

    task automatic t_status();
        logic [7:0] d;
        cfg = 8'h80;
        peek(1'b1, 1'b0, d);
        check("R4 inverted empty bit", {8'd0, d}, 16'h0000);
        check("R8 stat invert leaves pin", {15'd0, obe_pin}, 16'd1);
        cwrite(16'h0F0F);
        peek(1'b1, 1'b0, d);
        check("R4 inverted empty when clear", {8'd0, d}, 16'h0001);
        check("R8 empty pin low", {15'd0, obe_pin}, 16'd0);
        hwrite(1'b0, 1'b0, 8'h5A);
        peek(1'b1, 1'b0, d);
        check("R4 full bit position", {8'd0, d}, 16'h0003);
        cread();
        hread(1'b0, 1'b0, d);
    endtask

    task automatic t_pins();
        cfg = 8'h02;
        #1;
        check("R8 inverted full pin", {15'd0, ibf_pin}, 16'd1);
        check("R8 inverted empty pin", {15'd0, obe_pin}, 16'd0);
        cfg = 8'h20;
        #1;
        check("R9 merged pin with empty", {15'd0, ibf_pin}, 16'd1);
        cwrite(16'h0001);
        check("R9 merged pin idle", {15'd0, ibf_pin}, 16'd0);
        hwrite(1'b0, 1'b0, 8'h01);
        check("R9 merged pin with full", {15'd0, ibf_pin}, 16'd1);
        cfg = 8'hA2;
        #1;
        check("R9 merged inverted", {15'd0, ibf_pin}, 16'd0);
        check("R8 inverted empty with stat invert", {15'd0, obe_pin}, 16'd1);
        cfg = 8'h00;
        cread();
    endtask

    task automatic t_collision();
        logic [7:0] d;
        cfg = 8'h00;
        @(negedge clk);
        host_sel_stat = 1'b0; host_sel_byte = 1'b0; host_wdata = 8'h66;
        host_wr = 1'b1; cpu_rd_in = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cpu_rd_in = 1'b0;
        #1;
        check("R7 host write beats cpu read", {15'd0, ibf_pin}, 16'd1);
        @(negedge clk);
        host_rd = 1'b1; cpu_wr_out = 1'b1; cpu_out_word = 16'h5555;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; cpu_wr_out = 1'b0;
        #1;
        check("R7 host reads old byte in collision", {8'd0, d}, 16'h0001);
        check("R7 cpu write beats host read", {15'd0, obe_pin}, 16'd0);
        peek(1'b0, 1'b0, d);
        check("R7 new outbound word loaded", {8'd0, d}, 16'h0055);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_byte_mode();
        t_reserved();
        t_word_mode();
        t_swap();
        t_status();
        t_pins();
        t_collision();
        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule